// File: doc/BRIEF.md
# Serial Port Register File with Receive Queue

This block is the software-facing half of a serial port. A processor reaches it over a plain 32-bit register bus with separate read and write strobes, a byte address, write data and registered read data. Incoming bytes arrive on a valid/ready byte stream and wait in an eight-entry queue until software reads the data register. Each write to that same data register sends one byte out on the transmit stream.

The block keeps two interrupt sources. One fires when the queue fill reaches a programmable threshold. The other fires on each transmitted byte. Both feed a single level interrupt output, gated by an enable mask. Line timing, bit serialisation, handshake pins, DMA and wakeup are handled elsewhere. Their registers here only hold whatever software writes into them.

Registers sit at word offsets, and address bits [1:0] are ignored:

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | status |
| 0x08 | interrupt enable |
| 0x0C | interrupt flags |
| 0x10 | divider |
| 0x14 | oversampling |
| 0x18 | peek |
| 0x1C | pin |
| 0x20 | data |
| 0x24 | DMA |
| 0x28 | wakeup enable |
| 0x2C | wakeup flags |

Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high, and holds until the next read.

Top module: `uart_csr`

## Requirements
- R1: The receive queue holds 8 bytes and returns them in arrival order. While 8 bytes are held, `rx_ready` is low.
- R2: `rx_ready` is high only while control bit 15 (clock enable) is set and the queue is not full. With bit 15 clear, no byte enters the queue.
- R3: On every cycle that accepts a byte, flag bit 4 is set if the resulting fill level is greater than or equal to control bits [3:0]. A threshold above 8 never sets it.
- R4: `irq` is high exactly when some bit is set in both the flag register and the enable register (0x08).
- R5: A write to the flag register (0x0C) clears each bit written as 1 and leaves every other bit unchanged. If a set event falls in the same cycle, the set wins.
- R6: A control write with bit 5 set empties the queue. A byte offered in that same cycle is dropped.
- R7: The stored control value always reads back bits 4 and 5 as 0. A control write with bit 15 set also stores bit 17 as 1.
- R8: A status read (0x04) returns the following: the fill level in bits [11:8], bit 4 set when the queue is empty, bit 6 always set, and all other bits 0. Writes to status have no effect.
- R9: A data read (0x20) returns the oldest byte and removes it, or returns 0 when the queue is empty. A push and a pop in the same cycle leave the fill level unchanged.
- R10: A peek read (0x18) returns the oldest byte without removing it, or returns 0 when the queue is empty.
- R11: A data write (0x20) drives `tx_valid` high for exactly the next cycle, with `tx_data` equal to write-data bits [7:0]. It also sets flag bit 6.
- R12: After reset the following registers read 0: control, enable, flags, oversampling, DMA and both wakeup registers. The pin register (0x1C) reads 0x2, and the queue is empty. The divider, oversampling, pin, DMA and wakeup registers read back the last value written.
- R13: Offsets not listed above read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte can be accepted |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
Bus activity and stream arrivals are independent, so several operations can land on the same clock edge. The bench forces three such collisions:
- a data-register pop in the same cycle as an accepted byte, judged by the popped value and a fill level that stays the same;
- a flag-clear write in the same cycle as a threshold-crossing arrival, judged by the flag staying set;
- a flush in the same cycle as an offered byte, judged by a fill level of zero.

A threshold sweep over all sixteen values then fills and drains the queue and compares flags, interrupt and data against a queue model in the bench.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
   localparam logic [7:0] OFS_CTRL  = 8'h00;
   localparam logic [7:0] OFS_STAT  = 8'h04;
   localparam logic [7:0] OFS_IEN   = 8'h08;
   localparam logic [7:0] OFS_IFL   = 8'h0C;
   localparam logic [7:0] OFS_DIV   = 8'h10;
   localparam logic [7:0] OFS_OSR   = 8'h14;
   localparam logic [7:0] OFS_PEEK  = 8'h18;
   localparam logic [7:0] OFS_PIN   = 8'h1C;
   localparam logic [7:0] OFS_DATA  = 8'h20;
   localparam logic [7:0] OFS_DMA   = 8'h24;
   localparam logic [7:0] OFS_WKEN  = 8'h28;
   localparam logic [7:0] OFS_WKFL  = 8'h2C;

   localparam int CTRL_THR_W    = 4;
   localparam int CTRL_FLUSH_TX = 4;
   localparam int CTRL_FLUSH_RX = 5;
   localparam int CTRL_CLK_EN   = 15;
   localparam int CTRL_CLK_RDY  = 17;

   localparam int ST_RX_EMPTY = 4;
   localparam int ST_TX_EMPTY = 6;
   localparam int ST_LVL_LSB  = 8;
   localparam int ST_LVL_W    = 4;

   localparam int IF_RX_THR = 4;
   localparam int IF_TX_HE  = 6;

   localparam logic [31:0] PIN_RESET = 32'h0000_0002;
endpackage

// File: rtl/uart_csr_fifo.sv
module uart_csr_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [W-1:0]                  din,
   input  logic                          pop,
   input  logic                          flush,
   output logic [W-1:0]                  head,
   output logic [$clog2(DEPTH+1)-1:0]    level,
   output logic                          full,
   output logic                          empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_csr_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]     slot [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [LVL_W-1:0] cnt;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && !flush && wr_ptr == PTR_W'(g)) slot[g] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         cnt <= cnt + LVL_W'(push) - LVL_W'(pop);
      end
   end

   assign head  = slot[rd_ptr];
   assign level = cnt;
   assign full  = (cnt == LVL_W'(DEPTH));
   assign empty = (cnt == '0);

   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LVL_W'(DEPTH));
   p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   p_pop_only_filled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/uart_csr_flags.sv
module uart_csr_flags
   import uart_csr_pkg::*;
#(
   parameter int W       = 32,
   parameter int IRQ_REG = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_we,
   input  logic [W-1:0] clr_mask,
   input  logic         set_thr,
   input  logic         set_tx,
   input  logic [W-1:0] enable,
   output logic [W-1:0] flags,
   output logic         irq
);
   if (W <= IF_TX_HE || W <= IF_RX_THR) begin : g_bad_w
      $error("uart_csr_flags: W too small for flag positions");
   end

   logic [W-1:0] fl_q, fl_d;

   always_comb begin
      fl_d = fl_q & ~(clr_we ? clr_mask : '0);
      if (set_thr) fl_d[IF_RX_THR] = 1'b1;
      if (set_tx)  fl_d[IF_TX_HE]  = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fl_q <= '0;
      else        fl_q <= fl_d;
   end

   assign flags = fl_q;

   if (IRQ_REG != 0) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(fl_d & enable);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(fl_q & enable);
   end

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_mask[IF_RX_THR] && !set_thr) |=> !flags[IF_RX_THR]);
   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_thr |=> flags[IF_RX_THR]);
   p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && $past(rst_n)) |=> flags[IF_TX_HE] || !$past(flags[IF_TX_HE]));
endmodule

// File: rtl/uart_csr.sv
module uart_csr
   import uart_csr_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int ADDR_W  = 10,
   parameter int IRQ_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              irq
);
   localparam int LVL_W  = $clog2(DEPTH+1);
   localparam int WORD_W = ADDR_W - 2;
   localparam int CMP_W  = ((LVL_W > CTRL_THR_W) ? LVL_W : CTRL_THR_W) + 1;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("uart_csr: ADDR_W must cover the register window");
   end
   if (LVL_W > ST_LVL_W) begin : g_bad_lvl
      $error("uart_csr: DEPTH too large for status level field");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a[ADDR_W-1:2] == WORD_W'(ofs[7:2]);
   endfunction

   logic unused_addr_lsb;
   assign unused_addr_lsb = ^bus_addr[1:0];

   logic [31:0] ctrl_q, ien_q, div_q, osr_q, pin_q, dma_q, wken_q, wkfl_q;
   logic [31:0] ctrl_wv, flags, rd_mux;
   logic        wr_ctrl, wr_ifl, wr_data, rd_data, flush;
   logic        push, pop, thr_hit, fifo_full, fifo_empty;
   logic [7:0]  head;
   logic [LVL_W-1:0] level;
   logic [CMP_W-1:0] lvl_after;

   assign wr_ctrl = bus_wr && hit(bus_addr, OFS_CTRL);
   assign wr_ifl  = bus_wr && hit(bus_addr, OFS_IFL);
   assign wr_data = bus_wr && hit(bus_addr, OFS_DATA);
   assign rd_data = bus_rd && hit(bus_addr, OFS_DATA);
   assign flush   = wr_ctrl && bus_wdata[CTRL_FLUSH_RX];

   assign rx_ready = ctrl_q[CTRL_CLK_EN] && !fifo_full;
   assign push     = rx_valid && rx_ready && !flush;
   assign pop      = rd_data && !fifo_empty && !flush;

   assign lvl_after = CMP_W'(level) + CMP_W'(1) - CMP_W'(pop);
   assign thr_hit   = push && (lvl_after >= CMP_W'(ctrl_q[CTRL_THR_W-1:0]));

   always_comb begin
      ctrl_wv = bus_wdata;
      ctrl_wv[CTRL_FLUSH_RX] = 1'b0;
      ctrl_wv[CTRL_FLUSH_TX] = 1'b0;
      if (bus_wdata[CTRL_CLK_EN]) ctrl_wv[CTRL_CLK_RDY] = 1'b1;
   end

   uart_csr_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(rx_data), .pop(pop),
      .flush(flush), .head(head), .level(level), .full(fifo_full),
      .empty(fifo_empty));

   uart_csr_flags #(.W(32), .IRQ_REG(IRQ_REG)) u_flags (
      .clk(clk), .rst_n(rst_n), .clr_we(wr_ifl), .clr_mask(bus_wdata),
      .set_thr(thr_hit), .set_tx(wr_data), .enable(ien_q), .flags(flags),
      .irq(irq));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0; ien_q <= '0; div_q <= '0; osr_q <= '0;
         pin_q  <= PIN_RESET; dma_q <= '0; wken_q <= '0; wkfl_q <= '0;
      end else if (bus_wr) begin
         if (wr_ctrl)                  ctrl_q <= ctrl_wv;
         if (hit(bus_addr, OFS_IEN))   ien_q  <= bus_wdata;
         if (hit(bus_addr, OFS_DIV))   div_q  <= bus_wdata;
         if (hit(bus_addr, OFS_OSR))   osr_q  <= bus_wdata;
         if (hit(bus_addr, OFS_PIN))   pin_q  <= bus_wdata;
         if (hit(bus_addr, OFS_DMA))   dma_q  <= bus_wdata;
         if (hit(bus_addr, OFS_WKEN))  wken_q <= bus_wdata;
         if (hit(bus_addr, OFS_WKFL))  wkfl_q <= bus_wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit(bus_addr, OFS_CTRL)) rd_mux = ctrl_q;
      if (hit(bus_addr, OFS_STAT)) begin
         rd_mux[ST_LVL_LSB +: ST_LVL_W] = ST_LVL_W'(level);
         rd_mux[ST_RX_EMPTY] = fifo_empty;
         rd_mux[ST_TX_EMPTY] = 1'b1;
      end
      if (hit(bus_addr, OFS_IEN))  rd_mux = ien_q;
      if (hit(bus_addr, OFS_IFL))  rd_mux = flags;
      if (hit(bus_addr, OFS_DIV))  rd_mux = div_q;
      if (hit(bus_addr, OFS_OSR))  rd_mux = osr_q;
      if (hit(bus_addr, OFS_PEEK) && !fifo_empty) rd_mux = {24'h0, head};
      if (hit(bus_addr, OFS_PIN))  rd_mux = pin_q;
      if (hit(bus_addr, OFS_DATA) && !fifo_empty) rd_mux = {24'h0, head};
      if (hit(bus_addr, OFS_DMA))  rd_mux = dma_q;
      if (hit(bus_addr, OFS_WKEN)) rd_mux = wken_q;
      if (hit(bus_addr, OFS_WKFL)) rd_mux = wkfl_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         tx_valid  <= 1'b0;
         tx_data   <= '0;
      end else begin
         if (bus_rd) bus_rdata <= rd_mux;
         tx_valid <= wr_data;
         if (wr_data) tx_data <= bus_wdata[7:0];
      end
   end

   p_refuse_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CTRL_CLK_EN] |=> level <= $past(level));
   p_clk_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[CTRL_CLK_EN]) |=> ctrl_q[CTRL_CLK_RDY]);
   p_no_flush_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ctrl_q[CTRL_FLUSH_RX] == 1'b0 && ctrl_q[CTRL_FLUSH_TX] == 1'b0));
   p_tx_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> (tx_valid && flags[IF_TX_HE]));
   p_steady_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(level));
endmodule

// File: tb/uart_csr_test.sv
module uart_csr_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready, tx_valid, irq;
   logic [7:0]  tx_data;

   always #2 clk = ~clk;

   uart_csr uut (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq));

   int   checks = 0, bad = 0;
   bit   done = 0;
   logic tx_seen;
   logic [7:0] tx_byte;
   logic [7:0] q[$];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [9:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      tx_seen = tx_valid; tx_byte = tx_data;
   endtask

   task automatic rd(logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic push(logic [7:0] b, output logic acc);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b; acc = rx_ready;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_up();
   end

   initial begin
      logic [31:0] d;
      logic acc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset values
      rd(10'h00, d); check("R12 ctrl reset", d, 0);
      rd(10'h08, d); check("R12 ien reset", d, 0);
      rd(10'h0C, d); check("R12 flags reset", d, 0);
      rd(10'h14, d); check("R12 osr reset", d, 0);
      rd(10'h1C, d); check("R12 pin reset", d, 32'h2);
      rd(10'h24, d); check("R12 dma reset", d, 0);
      rd(10'h28, d); check("R12 wken reset", d, 0);
      rd(10'h2C, d); check("R12 wkfl reset", d, 0);
      rd(10'h04, d); check("R8 status reset", d, 32'h50);
      check("R4 irq reset", irq, 0);

      // R2 refused while clock disabled
      check("R2 ready off", rx_ready, 0);
      push(8'h11, acc); check("R2 accept off", acc, 0);
      rd(10'h04, d); check("R2 level off", d, 32'h50);

      // R12 storage, R13 unmapped, R8 status ignores writes
      for (int i = 0; i < 6; i++) begin
         logic [9:0] a;
         logic [31:0] v;
         a = (i == 0) ? 10'h10 : (i == 1) ? 10'h14 : (i == 2) ? 10'h1C :
             (i == 3) ? 10'h24 : (i == 4) ? 10'h28 : 10'h2C;
         v = 32'hA5C3_0000 ^ (32'h1111_1111 * i) ^ 32'(a);
         wr(a, v); rd(a, d); check("R12 storage", d, v);
      end
      wr(10'h30, 32'hFFFF_FFFF); rd(10'h30, d); check("R13 unmapped 0x30", d, 0);
      rd(10'h3FC, d); check("R13 unmapped top", d, 0);
      wr(10'h04, 32'hFFFF_FFFF); rd(10'h04, d); check("R8 status write ignored", d, 32'h50);

      // R7 control storage rules
      wr(10'h00, 32'h0000_803A); rd(10'h00, d); check("R7 ctrl with enable", d, 32'h0002_800A);
      wr(10'h00, 32'h0000_0033); rd(10'h00, d); check("R7 ctrl without enable", d, 32'h0000_0003);

      // R11 transmit
      wr(10'h20, 32'h0000_01A5);
      check("R11 tx_valid", tx_seen, 1); check("R11 tx_data", tx_byte, 8'hA5);
      @(negedge clk); check("R11 tx pulse ends", tx_valid, 0);
      rd(10'h0C, d); check("R11 tx flag", d[6], 1);
      wr(10'h0C, 32'h40); rd(10'h0C, d); check("R5 clear tx flag", d, 0);

      // R3 R4 R1 R8 R9 R10 threshold sweep
      for (int thr = 0; thr < 16; thr++) begin
         logic [31:0] en;
         en = (thr % 2) ? 32'h10 : 32'h0;
         wr(10'h00, 32'h8020 | 32'(thr));
         wr(10'h0C, 32'hFFFF_FFFF);
         wr(10'h08, en);
         q.delete();
         for (int k = 1; k <= 8; k++) begin
            logic [7:0] b;
            logic ef;
            b = 8'(thr * 16 + k);
            push(b, acc); check("R1 accept", acc, 1);
            q.push_back(b);
            ef = (k >= thr);
            rd(10'h0C, d); check("R3 threshold flag", d, ef ? 32'h10 : 32'h0);
            check("R4 irq", irq, ef && (thr % 2 == 1));
         end
         check("R1 ready when full", rx_ready, 0);
         push(8'hEE, acc); check("R1 full refuse", acc, 0);
         rd(10'h04, d); check("R8 status full", d, 32'h840);
         rd(10'h18, d); check("R10 peek", d, 32'(q[0]));
         rd(10'h04, d); check("R10 peek keeps level", d, 32'h840);
         for (int k = 0; k < 8; k++) begin
            rd(10'h20, d); check("R9 pop order", d, 32'(q.pop_front()));
         end
         rd(10'h20, d); check("R9 empty pop", d, 0);
         rd(10'h18, d); check("R10 empty peek", d, 0);
         rd(10'h04, d); check("R8 status empty", d, 32'h50);
      end

      // R6 flush
      wr(10'h00, 32'h8000);
      push(8'h01, acc); push(8'h02, acc); push(8'h03, acc);
      rd(10'h04, d); check("R8 level 3", d, 32'h340);
      wr(10'h00, 32'h8020); rd(10'h04, d); check("R6 flush", d, 32'h50);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 10'h00; bus_wdata = 32'h8020;
      rx_valid = 1'b1; rx_data = 8'h77;
      @(negedge clk);
      bus_wr = 1'b0; rx_valid = 1'b0;
      rd(10'h04, d); check("R6 flush drops same-cycle byte", d, 32'h50);

      // R9 simultaneous push and pop
      push(8'hA1, acc); push(8'hA2, acc); push(8'hA3, acc);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'hA4;
      bus_rd = 1'b1; bus_addr = 10'h20;
      @(negedge clk);
      rx_valid = 1'b0; bus_rd = 1'b0;
      check("R9 pop during push", bus_rdata, 32'hA1);
      rd(10'h04, d); check("R9 level unchanged", d, 32'h340);
      rd(10'h20, d); check("R9 order after overlap", d, 32'hA2);
      rd(10'h20, d); check("R9 order after overlap", d, 32'hA3);
      rd(10'h20, d); check("R9 order after overlap", d, 32'hA4);

      // R5 set wins over same-cycle clear
      wr(10'h00, 32'h8021); wr(10'h0C, 32'hFFFF_FFFF); wr(10'h08, 32'h10);
      push(8'h55, acc);
      rd(10'h0C, d); check("R3 flag at one", d, 32'h10);
      wr(10'h20, 32'h5A);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 10'h0C; bus_wdata = 32'h10;
      rx_valid = 1'b1; rx_data = 8'h66;
      @(negedge clk);
      bus_wr = 1'b0; rx_valid = 1'b0;
      rd(10'h0C, d); check("R5 set wins", d, 32'h50);
      wr(10'h0C, 32'h40); rd(10'h0C, d); check("R5 partial clear", d, 32'h10);
      check("R4 irq with rx flag", irq, 1);
      wr(10'h0C, 32'h10); rd(10'h0C, d); check("R5 full clear", d, 0);
      check("R4 irq cleared", irq, 0);

      finish_up();
   end
endmodule